// File: doc/BRIEF.md
# Receive Special-Character Detector

This block sits beside a UART receiver. It examines every character that the receiver accepts. Each character goes on to the receive FIFO one cycle later, and the block does not change it. Four 8-bit key registers hold the values to look for. A 2-bit mode field selects how those keys are used: detection off, single-character matching against the two tail keys, or a two-character sequence made of a lead key followed directly by its tail key. When a match completes, the block pulses a hit strobe together with the FIFO write of that character. It also sets a sticky interrupt flag, which stays set until a clear-on-read strobe arrives.

When automatic XON/XOFF flow control is enabled, the two lead keys belong to the flow-control logic. In that case every non-zero mode falls back to single-character matching on the two tail keys. A qualifier option replaces the low nibble of the compared value with four GPIO input levels, so that the key's low nibble matches a pin pattern rather than the character.

A small state machine tracks sequences. It has three states. ST_IDLE means no lead is held. ST_LEAD_A means key 0 has been seen in mode 10. ST_LEAD_B means key 2 has been seen in mode 11. The transitions are:
- arm-A: ST_IDLE to ST_LEAD_A.
- arm-B: ST_IDLE to ST_LEAD_B.
- complete or break: a lead state returns to ST_IDLE on the next accepted character, whatever that character is.
- abort: a lead state returns to ST_IDLE at once when the active mode no longer matches it.

Top module: `spc_detect`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, fifo_wr_en, spc_hit and spc_irq are 0.
- R2: Every character accepted with rx_valid high appears unchanged on fifo_wr_data, with fifo_wr_en high, exactly one cycle later. This holds whether or not it matches. fifo_wr_en is low in the cycle after rx_valid is low.
- R3: When det_en is low, or mode_sel is 00, spc_hit never asserts and spc_irq is never set.
- R4: With mode_sel 01 and xflow_en low, a character equal to key 1 or to key 3 asserts spc_hit in the same cycle as its FIFO write. Key 0 and key 2 never match alone.
- R5: With mode_sel 10 and xflow_en low, key 0 followed by key 1 as the next accepted character asserts spc_hit on the key-1 write. Key 1 without a held lead does not match.
- R6: With mode_sel 11 and xflow_en low, key 2 followed by key 3 as the next accepted character asserts spc_hit on the key-3 write.
- R7: A held lead is dropped by any next accepted character other than the tail key, including a repeat of the lead key. That character does not arm a new lead.
- R8: With xflow_en high and mode_sel non-zero, only single matches on key 1 and key 3 apply. Lead keys never arm a sequence.
- R9: With gpio_qual_en high, the compared value is the character's upper 4 bits above gpio_lvl[3:0] in bits 3:0.
- R10: spc_irq rises together with spc_hit. It stays high until a cycle with irq_rd_clr high and no new hit, after which it reads 0. A hit in the same cycle as a clear keeps it at 1.
- R11: Cycles with rx_valid low between a lead and its tail do not break the sequence.
- R12: Changing the mode so that it no longer selects the held pair discards the lead. A tail key arriving after the mode is restored does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receiver has a character this cycle |
| rx_data | input | DW | Received character |
| match_keys | input | 4 x DW | Key registers; index 0/1 form pair A, 2/3 form pair B |
| mode_sel | input | 2 | 00 off, 01 single, 10 pair A, 11 pair B |
| det_en | input | 1 | Detection enable |
| xflow_en | input | 1 | Automatic XON/XOFF flow control enabled |
| gpio_qual_en | input | 1 | Replace low compare bits with GPIO levels |
| gpio_lvl | input | GW | GPIO input levels |
| irq_rd_clr | input | 1 | Clear-on-read strobe for the interrupt flag |
| fifo_wr_en | output | 1 | Write strobe toward the receive FIFO |
| fifo_wr_data | output | DW | Character toward the receive FIFO |
| spc_hit | output | 1 | A match completed on this FIFO write |
| spc_irq | output | 1 | Sticky special-character interrupt flag |

## Verification
The clear-on-read strobe and a fresh match can land in the same cycle. The bench provokes this by presenting a matching key while it pulses irq_rd_clr with the flag already set. It judges the result by requiring the flag to stay high, and then to fall on a following clear with no match. A second overlap is a mode change in the cycle after a lead is armed. There the bench requires the held lead to be dropped rather than completed, and a behavioural model compares every output on every clock.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int unsigned NKEY       = 4;
    localparam int unsigned KEY_LEAD_A = 0;
    localparam int unsigned KEY_TAIL_A = 1;
    localparam int unsigned KEY_LEAD_B = 2;
    localparam int unsigned KEY_TAIL_B = 3;

    typedef enum logic [1:0] {
        SEL_OFF    = 2'b00,
        SEL_SINGLE = 2'b01,
        SEL_PAIR_A = 2'b10,
        SEL_PAIR_B = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_LEAD_A = 2'b01,
        ST_LEAD_B = 2'b10
    } seq_st_e;

    typedef struct packed {
        logic single;
        logic pair_a;
        logic pair_b;
    } role_t;

endpackage

// File: rtl/spc_mode.sv
module spc_mode
    import spc_pkg::*;
(
    input  logic       det_en,
    input  logic       xflow_en,
    input  logic [1:0] mode_sel,
    output role_t      role
);

    sel_e sel;

    assign sel = sel_e'(mode_sel);

    always_comb begin
        role = '0;
        if (det_en) begin
            unique case (sel)
                SEL_OFF:    role = '0;
                SEL_SINGLE: role.single = 1'b1;
                SEL_PAIR_A: begin
                    // flow control owns the lead keys: fall back to singles
                    role.single = xflow_en;
                    role.pair_a = !xflow_en;
                end
                SEL_PAIR_B: begin
                    role.single = xflow_en;
                    role.pair_b = !xflow_en;
                end
                default:    role = '0;
            endcase
        end
    end

endmodule

// File: rtl/spc_cmp.sv
module spc_cmp
    import spc_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned GW = 4
) (
    input  logic [DW-1:0]           rx_data,
    input  logic [NKEY-1:0][DW-1:0] match_keys,
    input  logic                    gpio_qual_en,
    input  logic [GW-1:0]           gpio_lvl,
    output logic [NKEY-1:0]         key_eq
);

    localparam int unsigned HI_W = DW - GW;

    logic [DW-1:0] cmp_val;

    always_comb begin
        if (gpio_qual_en) begin
            cmp_val = {rx_data[DW-1 -: HI_W], gpio_lvl};
        end else begin
            cmp_val = rx_data;
        end
    end

    for (genvar k = 0; k < NKEY; k++) begin : g_key
        assign key_eq[k] = (cmp_val == match_keys[k]);
    end

endmodule

// File: rtl/spc_seq.sv
module spc_seq
    import spc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  role_t           role,
    input  logic [NKEY-1:0] key_eq,
    output logic            hit_now,
    output logic            hit_q
);

    seq_st_e st_q;
    seq_st_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rx_valid && role.pair_a && key_eq[KEY_LEAD_A]) begin
                    st_d = ST_LEAD_A;                       // arm-A
                end else if (rx_valid && role.pair_b && key_eq[KEY_LEAD_B]) begin
                    st_d = ST_LEAD_B;                       // arm-B
                end
            end
            ST_LEAD_A: begin
                if (!role.pair_a) begin
                    st_d = ST_IDLE;                         // abort
                end else if (rx_valid) begin
                    st_d = ST_IDLE;                         // complete or break
                end
            end
            ST_LEAD_B: begin
                if (!role.pair_b) begin
                    st_d = ST_IDLE;                         // abort
                end else if (rx_valid) begin
                    st_d = ST_IDLE;                         // complete or break
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // match decision for the character presented this cycle
    always_comb begin
        hit_now = 1'b0;
        if (rx_valid) begin
            unique case (st_q)
                ST_IDLE:   hit_now = role.single &&
                                     (key_eq[KEY_TAIL_A] || key_eq[KEY_TAIL_B]);
                ST_LEAD_A: hit_now = role.pair_a && key_eq[KEY_TAIL_A];
                ST_LEAD_B: hit_now = role.pair_b && key_eq[KEY_TAIL_B];
                default:   hit_now = 1'b0;
            endcase
        end
    end

    // output register, aligned with the FIFO write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit_now;
        end
    end

endmodule

// File: rtl/spc_irq.sv
module spc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;           // a new hit wins over a clear
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/spc_detect.sv
module spc_detect
    import spc_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned GW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [DW-1:0]           rx_data,
    input  logic [NKEY-1:0][DW-1:0] match_keys,
    input  logic [1:0]              mode_sel,
    input  logic                    det_en,
    input  logic                    xflow_en,
    input  logic                    gpio_qual_en,
    input  logic [GW-1:0]           gpio_lvl,
    input  logic                    irq_rd_clr,
    output logic                    fifo_wr_en,
    output logic [DW-1:0]           fifo_wr_data,
    output logic                    spc_hit,
    output logic                    spc_irq
);

    role_t           role;
    logic [NKEY-1:0] key_eq;
    logic            hit_now;

    spc_mode u_mode (
        .det_en   (det_en),
        .xflow_en (xflow_en),
        .mode_sel (mode_sel),
        .role     (role)
    );

    spc_cmp #(.DW(DW), .GW(GW)) u_cmp (
        .rx_data      (rx_data),
        .match_keys   (match_keys),
        .gpio_qual_en (gpio_qual_en),
        .gpio_lvl     (gpio_lvl),
        .key_eq       (key_eq)
    );

    spc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .role     (role),
        .key_eq   (key_eq),
        .hit_now  (hit_now),
        .hit_q    (spc_hit)
    );

    spc_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit_now),
        .clr_i  (irq_rd_clr),
        .flag_q (spc_irq)
    );

    // pass every accepted character on toward the receive FIFO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr_en   <= 1'b0;
            fifo_wr_data <= '0;
        end else begin
            fifo_wr_en <= rx_valid;
            if (rx_valid) begin
                fifo_wr_data <= rx_data;
            end
        end
    end

endmodule

// File: rtl/spc_detect_chk.sv
module spc_detect_chk
    import spc_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned GW = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rx_valid,
    input logic [DW-1:0]           rx_data,
    input logic [NKEY-1:0][DW-1:0] match_keys,
    input logic [1:0]              mode_sel,
    input logic                    det_en,
    input logic                    xflow_en,
    input logic                    gpio_qual_en,
    input logic [GW-1:0]           gpio_lvl,
    input logic                    irq_rd_clr,
    input logic                    fifo_wr_en,
    input logic [DW-1:0]           fifo_wr_data,
    input logic                    spc_hit,
    input logic                    spc_irq
);

    p_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fifo_wr_en && fifo_wr_data == $past(rx_data)));

    p_nowr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fifo_wr_en);

    p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_en || mode_sel == 2'b00) |=> !spc_hit);

    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && det_en && !xflow_en && mode_sel == 2'b01 && !gpio_qual_en
         && rx_data == match_keys[KEY_TAIL_A]) |=> spc_hit);

    p_xflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && xflow_en && mode_sel != 2'b00 && !gpio_qual_en
         && rx_data != match_keys[KEY_TAIL_A]
         && rx_data != match_keys[KEY_TAIL_B]) |=> !spc_hit);

    p_hit_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spc_hit |-> (spc_irq && fifo_wr_en));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spc_irq && !irq_rd_clr) |=> spc_irq);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_rd_clr) && !spc_hit) |-> !spc_irq);

endmodule

bind spc_detect spc_detect_chk #(.DW(DW), .GW(GW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .match_keys   (match_keys),
    .mode_sel     (mode_sel),
    .det_en       (det_en),
    .xflow_en     (xflow_en),
    .gpio_qual_en (gpio_qual_en),
    .gpio_lvl     (gpio_lvl),
    .irq_rd_clr   (irq_rd_clr),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data),
    .spc_hit      (spc_hit),
    .spc_irq      (spc_irq)
);

// File: tb/spc_detect_tb.sv
`timescale 1ns/1ps
module spc_detect_tb;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_data = '0;
    logic [3:0][7:0] keys;
    logic [1:0]      mode_sel = 2'b00;
    logic            det_en = 1'b0;
    logic            xflow_en = 1'b0;
    logic            gq_en = 1'b0;
    logic [3:0]      gpio = 4'h0;
    logic            rd_clr = 1'b0;
    logic            fifo_wr_en;
    logic [7:0]      fifo_wr_data;
    logic            spc_hit;
    logic            spc_irq;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    // reference model state
    int         m_armed = 0;     // 0 none, 1 lead A held, 2 lead B held
    bit         m_wr = 1'b0;
    logic [7:0] m_data = '0;
    bit         m_hit = 1'b0;
    bit         m_irq = 1'b0;

    always #4 clk = ~clk;

    spc_detect u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .match_keys   (keys),
        .mode_sel     (mode_sel),
        .det_en       (det_en),
        .xflow_en     (xflow_en),
        .gpio_qual_en (gq_en),
        .gpio_lvl     (gpio),
        .irq_rd_clr   (rd_clr),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data),
        .spc_hit      (spc_hit),
        .spc_irq      (spc_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_update();
        logic [7:0] v;
        bit single, pa, pb, h;
        if (!rst_n) begin
            m_armed = 0; m_wr = 0; m_data = '0; m_hit = 0; m_irq = 0;
        end else begin
            v = gq_en ? {rx_data[7:4], gpio} : rx_data;
            single = det_en && ((mode_sel == 2'b01) || (mode_sel[1] && xflow_en));
            pa = det_en && !xflow_en && mode_sel == 2'b10;
            pb = det_en && !xflow_en && mode_sel == 2'b11;
            h = 0;
            if (rx_valid) begin
                if (single) h = (v == keys[1]) || (v == keys[3]);
                else if (pa && m_armed == 1) h = (v == keys[1]);
                else if (pb && m_armed == 2) h = (v == keys[3]);
            end
            if (pa) begin
                if (m_armed == 2) m_armed = 0;
                else if (rx_valid) m_armed = (m_armed == 1) ? 0 : ((v == keys[0]) ? 1 : 0);
            end else if (pb) begin
                if (m_armed == 1) m_armed = 0;
                else if (rx_valid) m_armed = (m_armed == 2) ? 0 : ((v == keys[2]) ? 2 : 0);
            end else begin
                m_armed = 0;
            end
            m_wr = rx_valid;
            if (rx_valid) m_data = rx_data;
            m_hit = h;
            if (h) m_irq = 1;
            else if (rd_clr) m_irq = 0;
        end
    endtask

    task automatic compare();
        check(fifo_wr_en == m_wr, cur_req, "fifo_wr_en", fifo_wr_en, m_wr);
        if (m_wr)
            check(fifo_wr_data == m_data, cur_req, "fifo_wr_data", fifo_wr_data, m_data);
        check(spc_hit == m_hit, cur_req, "spc_hit", spc_hit, m_hit);
        check(spc_irq == m_irq, cur_req, "spc_irq", spc_irq, m_irq);
    endtask

    task automatic step(input bit v, input logic [7:0] d, input bit clr);
        rx_valid = v;
        rx_data  = d;
        rd_clr   = clr;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        rx_valid = 1'b0;
        rd_clr   = 1'b0;
    endtask

    task automatic expect_hit(input bit e, input string req);
        check(spc_hit == e, req, "spc_hit literal", spc_hit, e);
    endtask

    task automatic expect_irq(input bit e, input string req);
        check(spc_irq == e, req, "spc_irq literal", spc_irq, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        keys[0] = 8'h11; keys[1] = 8'h13; keys[2] = 8'hA5; keys[3] = 8'h5A;

        // R1: reset with busy inputs
        cur_req = "R1";
        det_en = 1; mode_sel = 2'b01;
        step(1, 8'h13, 0);
        step(1, 8'h13, 0);
        check(!fifo_wr_en && !spc_hit && !spc_irq, "R1", "reset outputs",
              {fifo_wr_en, spc_hit, spc_irq}, 0);
        rst_n = 1;
        step(0, 8'h00, 0);
        check(!fifo_wr_en && !spc_hit && !spc_irq, "R1", "after reset",
              {fifo_wr_en, spc_hit, spc_irq}, 0);

        // R2/R3: forwarding with detection off
        cur_req = "R3";
        mode_sel = 2'b00;
        for (int i = 0; i < 6; i++) step(1, 8'(8'h10 + i * 3), 0);
        step(1, 8'h13, 0); expect_hit(0, "R3");
        cur_req = "R2";
        step(1, 8'hC7, 0);
        check(fifo_wr_data == 8'hC7 && fifo_wr_en, "R2", "forward", fifo_wr_data, 8'hC7);
        step(0, 8'h00, 0);
        check(!fifo_wr_en, "R2", "no write when idle", fifo_wr_en, 0);
        cur_req = "R3";
        det_en = 0; mode_sel = 2'b01;
        step(1, 8'h13, 0); expect_hit(0, "R3");
        expect_irq(0, "R3");

        // R4: single matches
        cur_req = "R4";
        det_en = 1;
        step(1, 8'h13, 0); expect_hit(1, "R4");
        step(1, 8'h5A, 0); expect_hit(1, "R4");
        step(1, 8'h11, 0); expect_hit(0, "R4");
        step(1, 8'hA5, 0); expect_hit(0, "R4");

        // R10: sticky flag, clear, clear colliding with hit
        cur_req = "R10";
        expect_irq(1, "R10");
        step(0, 8'h00, 0); expect_irq(1, "R10");
        step(1, 8'h13, 1); expect_irq(1, "R10");
        step(0, 8'h00, 1); expect_irq(0, "R10");
        step(1, 8'h99, 0); expect_irq(0, "R10");

        // R5: pair A
        cur_req = "R5";
        mode_sel = 2'b10;
        step(1, 8'h13, 0); expect_hit(0, "R5");
        step(1, 8'h11, 0); expect_hit(0, "R5");
        step(1, 8'h13, 0); expect_hit(1, "R5");

        // R11: gaps between lead and tail
        cur_req = "R11";
        step(1, 8'h11, 0);
        step(0, 8'h00, 0);
        step(0, 8'h00, 0);
        step(1, 8'h13, 0); expect_hit(1, "R11");

        // R7: broken sequences
        cur_req = "R7";
        step(1, 8'h11, 0);
        step(1, 8'h11, 0);
        step(1, 8'h13, 0); expect_hit(0, "R7");
        step(1, 8'h11, 0);
        step(1, 8'h42, 0);
        step(1, 8'h13, 0); expect_hit(0, "R7");

        // R12: mode change drops a held lead
        cur_req = "R12";
        step(1, 8'h11, 0);
        mode_sel = 2'b00;
        step(0, 8'h00, 0);
        mode_sel = 2'b10;
        step(1, 8'h13, 0); expect_hit(0, "R12");

        // R6: pair B
        cur_req = "R6";
        mode_sel = 2'b11;
        step(1, 8'h5A, 0); expect_hit(0, "R6");
        step(1, 8'hA5, 0); expect_hit(0, "R6");
        step(1, 8'h5A, 0); expect_hit(1, "R6");
        step(1, 8'h11, 0);
        step(1, 8'h13, 0); expect_hit(0, "R6");

        // R8: flow control reserves the lead keys
        cur_req = "R8";
        xflow_en = 1;
        step(1, 8'hA5, 0); expect_hit(0, "R8");
        step(1, 8'h42, 0); expect_hit(0, "R8");
        step(1, 8'h13, 0); expect_hit(1, "R8");
        mode_sel = 2'b10;
        step(1, 8'h11, 0); expect_hit(0, "R8");
        step(1, 8'h5A, 0); expect_hit(1, "R8");
        xflow_en = 0;

        // R9: GPIO qualification of the low nibble
        cur_req = "R9";
        mode_sel = 2'b01;
        gq_en = 1; gpio = 4'h3;
        step(1, 8'h1F, 0); expect_hit(1, "R9");
        gpio = 4'h0;
        step(1, 8'h13, 0); expect_hit(0, "R9");
        gpio = 4'hA;
        step(1, 8'h50, 0); expect_hit(1, "R9");
        gq_en = 0;

        // mixed stream against the model
        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            mode_sel = 2'(i / 10);
            step(i % 3 != 2, keys[i % 4] ^ ((i % 5 == 4) ? 8'h01 : 8'h00), i % 7 == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule